// File: doc/BRIEF.md
# Single-Precision Compare to Condition Flags

This block compares two 32-bit single-precision floating-point words, a first operand `op_d` and a second operand `op_m`. It returns the ordering as a 4-bit condition code, packed as {N, Z, C, V}, together with an invalid-operation indication. The ordering is found by integer comparison of the packed encodings. The magnitude bits are compared as an unsigned number and the sign bit reverses the outcome, so neither operand is unpacked or normalised. Zeros of opposite sign compare equal. An operand that is not a number makes the result unordered.

A caller can request a compare against positive zero, in which case the second operand is ignored. A mode input decides whether a quiet NaN raises invalid or only a signalling one does. The result is normally registered: an input strobe yields an output strobe one cycle later, and the flags hold their value between strobes. A parameter removes the register so the result appears in the same cycle.

Top module: `fcmp_flags`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero is a NaN. If either effective operand is a NaN, the flags are 4'b0011 (C and V), including when both operands are NaN.
- R2: `invalid` is set when either effective operand is a NaN with fraction bit 22 clear (a signalling NaN). No compare of two non-NaN operands sets `invalid`.
- R3: When `sig_quiet` is 1, any NaN operand, quiet or signalling, sets `invalid`.
- R4: Bit-identical non-NaN operands compare equal, and so do two zeros of either sign. Equal gives flags 4'b0110 (Z and C).
- R5: When the sign bits differ and the operands are neither equal nor NaN, a negative `op_d` gives 4'b1000 (N, less) and a positive `op_d` gives 4'b0010 (C, greater).
- R6: When the sign bits match and the operands are neither equal nor NaN, `op_d` is less than `op_m` exactly when its sign bit XOR (unsigned `op_d` < unsigned `op_m`) is 1. Less gives 4'b1000 and greater gives 4'b0010. This ordering covers infinities and denormals.
- R7: When `zero_cmp` is 1, positive zero (32'h0) is used as the second operand and the value on `op_m` has no effect on either output.
- R8: With the output register enabled (default), `out_valid` is high exactly one cycle after `in_valid` was high. `flags` and `invalid` show the result for that strobe and keep their value in cycles that follow a cycle without `in_valid`.
- R9: While reset is asserted and until the first strobe, `out_valid`, `flags` and `invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode inputs are valid this cycle |
| op_d | input | 32 | First operand, single-precision encoding |
| op_m | input | 32 | Second operand, single-precision encoding |
| zero_cmp | input | 1 | Compare `op_d` against +0 instead of `op_m` |
| sig_quiet | input | 1 | Quiet NaNs also raise invalid |
| out_valid | output | 1 | Result strobe |
| flags | output | 4 | Condition code {N, Z, C, V} |
| invalid | output | 1 | Invalid-operation indication |

## Verification
With the default register, every result is due exactly one clock edge after the cycle that drove `in_valid`. In cycles without a strobe, the previous flags must still be present one edge later. The bench drives inputs on the falling edge and keeps a behavioural model that advances by one cycle per clock. It compares all three outputs with the model on the next falling edge, so each check looks at the value produced by the single intervening rising edge. The checker asserts the same one-edge relation with `|=>` from the strobe cycle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    parameter int DEF_EXP_W  = 8;
    parameter int DEF_FRAC_W = 23;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic nzcv_t order_to_nzcv(input order_e ord);
        nzcv_t f;
        f = '0;
        unique case (ord)
            ORD_LT: f.n = 1'b1;
            ORD_EQ: begin f.z = 1'b1; f.c = 1'b1; end
            ORD_GT: f.c = 1'b1;
            ORD_UN: begin f.c = 1'b1; f.v = 1'b1; end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = fcmp_pkg::DEF_EXP_W,
    parameter int FRAC_W = fcmp_pkg::DEF_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  is_neg,
    output logic                  is_nan,
    output logic                  is_signal,
    output logic                  is_zero
);
    localparam int MSB = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f     = word[MSB-1:FRAC_W];
        frac_f    = word[FRAC_W-1:0];
        is_neg    = word[MSB];
        is_nan    = (&exp_f) && (|frac_f);
        // a clear top fraction bit marks a signalling NaN
        is_signal = is_nan && !frac_f[FRAC_W-1];
        is_zero   = ~|word[MSB-1:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] d_word,
    input  logic [EXP_W+FRAC_W:0] m_word,
    input  logic                  d_neg,
    input  logic                  m_neg,
    input  logic                  any_nan,
    input  logic                  both_zero,
    output order_e                ord
);
    logic raw_less;

    always_comb begin
        raw_less = d_word < m_word;
        if (any_nan) begin
            ord = ORD_UN;
        end else if (d_word == m_word || both_zero) begin
            ord = ORD_EQ;
        end else if (d_neg != m_neg) begin
            ord = d_neg ? ORD_LT : ORD_GT;
        end else if (d_neg ^ raw_less) begin
            // same sign: negative values order in reverse of their encoding
            ord = ORD_LT;
        end else begin
            ord = ORD_GT;
        end
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
#(
    parameter int EXP_W   = DEF_EXP_W,
    parameter int FRAC_W  = DEF_FRAC_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_d,
    input  logic [EXP_W+FRAC_W:0] op_m,
    input  logic                  zero_cmp,
    input  logic                  sig_quiet,
    output logic                  out_valid,
    output logic [3:0]            flags,
    output logic                  invalid
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 2;

    typedef struct packed {
        logic  vld;
        nzcv_t nzcv;
        logic  inv;
    } res_t;

    logic [WORD_W-1:0] opnd [N_OPS];
    logic [N_OPS-1:0]  neg_v, nan_v, sig_v, zero_v;
    order_e            ord;
    res_t              now_c, res_d, res_q;

    assign opnd[0] = op_d;
    assign opnd[1] = zero_cmp ? '0 : op_m;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word     (opnd[gi]),
            .is_neg   (neg_v[gi]),
            .is_nan   (nan_v[gi]),
            .is_signal(sig_v[gi]),
            .is_zero  (zero_v[gi])
        );
    end

    fcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
        .d_word   (opnd[0]),
        .m_word   (opnd[1]),
        .d_neg    (neg_v[0]),
        .m_neg    (neg_v[1]),
        .any_nan  (|nan_v),
        .both_zero(&zero_v),
        .ord      (ord)
    );

    always_comb begin
        now_c.vld  = in_valid;
        now_c.nzcv = order_to_nzcv(ord);
        now_c.inv  = (|sig_v) || (sig_quiet && (|nan_v));
    end

    if (REG_OUT) begin : g_reg
        always_comb begin
            res_d     = res_q;
            res_d.vld = in_valid;
            if (in_valid) begin
                res_d.nzcv = now_c.nzcv;
                res_d.inv  = now_c.inv;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            res_d = now_c;
            res_q = res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign flags     = res_q.nzcv;
    assign invalid   = res_q.inv;

endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] op_d,
    input logic [EXP_W+FRAC_W:0] op_m,
    input logic                  zero_cmp,
    input logic                  sig_quiet,
    input logic                  out_valid,
    input logic [3:0]            flags,
    input logic                  invalid
);
    localparam int MSB = EXP_W + FRAC_W;

    logic d_nan;
    assign d_nan = (&op_d[MSB-1:FRAC_W]) && (|op_d[FRAC_W-1:0]);

    if (REG_OUT) begin : g_seq
        assert_strobe_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(flags) && $stable(invalid)));
        assert_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (flags inside {4'b0011, 4'b0110, 4'b1000, 4'b0010}));
        assert_inv_unordered_R2: assert property (@(posedge clk) disable iff (!rst_n)
            invalid |-> (flags == 4'b0011));
        assert_quiet_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sig_quiet && d_nan) |=> invalid);
        assert_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !zero_cmp && !d_nan && op_d == op_m) |=> (flags == 4'b0110));
        assert_zero_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && zero_cmp && op_d[MSB-1:0] == '0) |=> (flags == 4'b0110 && !invalid));
    end else begin : g_cmb
        assert_comb_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
        assert_comb_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
            invalid |-> (flags == 4'b0011));
        assert_comb_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_quiet && d_nan) |-> invalid);
        assert_comb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (zero_cmp && op_d[MSB-1:0] == '0 && op_m != op_d) |-> (flags == 4'b0110));
    end
endmodule

bind fcmp_flags fcmp_flags_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .REG_OUT(REG_OUT)
) u_fcmp_flags_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_d     (op_d),
    .op_m     (op_m),
    .zero_cmp (zero_cmp),
    .sig_quiet(sig_quiet),
    .out_valid(out_valid),
    .flags    (flags),
    .invalid  (invalid)
);

// File: tb/test_fcmp_flags.sv
`timescale 1ns/1ps
module test_fcmp_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_d = '0;
    logic [31:0] op_m = '0;
    logic        zero_cmp = 1'b0;
    logic        sig_quiet = 1'b0;
    logic        out_valid;
    logic [3:0]  flags;
    logic        invalid;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic       exp_vld = 1'b0;
    logic [3:0] exp_flags = 4'b0000;
    logic       exp_inv = 1'b0;
    string      exp_tag = "R9";

    always #2.5 clk = ~clk;

    fcmp_flags i_fcmp_flags (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_d(op_d), .op_m(op_m),
        .zero_cmp(zero_cmp), .sig_quiet(sig_quiet), .out_valid(out_valid),
        .flags(flags), .invalid(invalid)
    );

    // behavioural model: value line with signed keys
    function automatic void ref_cmp(input logic [31:0] d, input logic [31:0] m_in,
                                    input logic zc, input logic sq,
                                    output logic [3:0] f, output logic inv);
        logic [31:0] m;
        bit dn, mn;
        longint kd, km;
        m  = zc ? 32'h0 : m_in;
        dn = (d[30:23] == 8'hFF) && (d[22:0] != 0);
        mn = (m[30:23] == 8'hFF) && (m[22:0] != 0);
        if (dn || mn) begin
            f   = 4'b0011;
            inv = sq || (dn && !d[22]) || (mn && !m[22]);
        end else begin
            kd  = d[31] ? -longint'(d[30:0]) : longint'(d[30:0]);
            km  = m[31] ? -longint'(m[30:0]) : longint'(m[30:0]);
            inv = 1'b0;
            if (kd == km)      f = 4'b0110;
            else if (kd < km)  f = 4'b1000;
            else               f = 4'b0010;
        end
    endfunction

    task automatic check_outputs();
        n_run++;
        if (out_valid !== exp_vld || flags !== exp_flags || invalid !== exp_inv) begin
            n_fail++;
            $display("FAIL %s: got vld=%b flags=%b inv=%b, expected vld=%b flags=%b inv=%b",
                     exp_tag, out_valid, flags, invalid, exp_vld, exp_flags, exp_inv);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic [31:0] m,
                        input logic zc, input logic sq, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        op_d      = d;
        op_m      = m;
        zero_cmp  = zc;
        sig_quiet = sq;
        exp_vld   = v;
        if (v) begin
            ref_cmp(d, m, zc, sq, exp_flags, exp_inv);
            exp_tag = tag;
        end else begin
            exp_tag = "R8";
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outputs();            // R9 during reset
        rst_n = 1'b1;
        // R9: first step checks the post-reset idle state
        step(1, 32'h7FC00000, 32'h3F800000, 0, 0, "R1");  // qNaN d
        step(1, 32'h3F800000, 32'hFFC00001, 0, 0, "R1");  // qNaN m
        step(1, 32'h7FC00000, 32'h7F800001, 0, 0, "R1");  // both NaN, one signalling
        step(1, 32'h7F800001, 32'h00000000, 0, 0, "R2");  // sNaN d
        step(1, 32'h3F800000, 32'hFF800010, 0, 0, "R2");  // sNaN m
        step(1, 32'h7F800000, 32'h7F7FFFFF, 0, 0, "R2");  // infinity is not NaN
        step(1, 32'h7FC00000, 32'h3F800000, 0, 1, "R3");
        step(1, 32'h3F800000, 32'hFFC12345, 0, 1, "R3");
        step(1, 32'h3F800000, 32'h3F800000, 0, 0, "R4");
        step(1, 32'h00000000, 32'h80000000, 0, 0, "R4");
        step(1, 32'h80000000, 32'h80000000, 0, 0, "R4");
        step(1, 32'hFF800000, 32'hFF800000, 0, 0, "R4");
        step(1, 32'hBF800000, 32'h3F800000, 0, 0, "R5");
        step(1, 32'h3F800000, 32'hBF800000, 0, 0, "R5");
        step(1, 32'h80000000, 32'h00000001, 0, 0, "R5");
        step(1, 32'h3F800000, 32'h40000000, 0, 0, "R6");
        step(1, 32'hBF800000, 32'hC0000000, 0, 0, "R6");
        step(1, 32'h7F800000, 32'h7F7FFFFF, 0, 0, "R6");
        step(1, 32'hFF800000, 32'hFF7FFFFF, 0, 0, "R6");
        step(1, 32'h00000001, 32'h00000002, 0, 0, "R6");
        step(1, 32'h80000002, 32'h80000001, 0, 0, "R6");
        step(1, 32'h3F800000, 32'h7F800001, 1, 0, "R7");  // m sNaN ignored
        step(1, 32'h80000000, 32'hBF800000, 1, 0, "R7");
        step(1, 32'hBF800000, 32'h7FC00000, 1, 1, "R7");
        step(1, 32'h7F800004, 32'h3F800000, 1, 0, "R7");
        step(1, 32'h7FC00000, 32'h00000000, 1, 1, "R7");
        step(0, 32'h7F800001, 32'h7F800001, 0, 1, "R8");  // no strobe: hold
        step(0, 32'hBF800000, 32'h3F800000, 0, 0, "R8");
        step(1, 32'h40000000, 32'h3F800000, 0, 0, "R8");
        step(0, 32'h00000000, 32'h00000000, 0, 0, "R8");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 5 == 0) a[30:23] = 8'hFF;
            if (i % 7 == 0) b = a;
            if (i % 11 == 0) b = a ^ 32'h80000000;
            if (i % 13 == 0) b[30:23] = a[30:23];
            step((i % 9) != 0, a, b, (i % 17) == 0, (i % 6) == 0, "R6");
        end
        step(0, 32'h0, 32'h0, 0, 0, "R8");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule